// File: doc/BRIEF.md
# Strobe Delay Eye Calibration Engine

This block finds a working read/write strobe timing for a DDR memory controller by brute force. It sweeps a two-level grid. The outer level is a write-strobe shift, and a companion output shift always follows it at a fixed offset. The inner level is one strobe delay value, copied to every byte lane. For each grid point the engine holds the controller in stop and applies the settings. It then releases the controller and waits for the delay line to lock and for memory initialisation to finish. After a settle interval it runs a memory test through a plain single-word port.

The memory test writes a structured 64-word pattern and reads every word back several times in a row. The first wrong word fails the point. Within one shift value, passing delays that sit next to each other form a run. The longest run seen so far is kept, and a run that only equals the best one still replaces it. At the end the engine programs the best shift with the midpoint of that run, restarts the controller and pulses `done`. If no point passes, it raises a flag instead of programming anything. If a status wait times out, it stops in a fatal state that still shows the settings it was trying.

Top module: `strobe_eye_cal`

## Requirements
- R1: After reset, `done`, `busy`, `ctlRun`, `memWe`, `memRe`, `noWindow` and `errTimeout` are all 0.
- R2: Points are visited with the shift outer, going from SHIFT_LO up to SHIFT_HI, and the delay inner, going from DLY_LO up to DLY_HI. `ctlOutShift` equals `ctlWrShift` + OUT_OFFSET. All LANES fields of `ctlLaneDly` (lane n at bits n*DLY_W upward) carry the same delay.
- R3: Settings change only while `ctlRun` is low. After `ctlRun` rises, no memory access occurs until `dllLocked` has been seen, then `initDone` has been seen, and then SETTLE_CYC further cycles have passed.
- R4: Word i of the write pattern is built as follows. Take base X from i[5:4]: 0 selects 00000000, 1 selects AAAAAAAA, 2 selects A5A5A5A5, 3 selects AA55AA55. The word is ~X when i[1] XOR i[3] is 1, and X otherwise.
- R5: All 64 words are written first. Each word is then read READS times back to back, words in ascending order, with read data taken one cycle after `memRe`. The first mismatch ends the point as a failure, with no further reads.
- R6: A failing point sets the current run length to zero, and so does moving to a new shift value. Each passing point adds one to the run length, and the first point of a run records its delay as the run start.
- R7: After each passing point, if the run length is greater than or equal to the best length so far, the length, the shift, the run start and the current delay become the new best. A later tie therefore replaces an earlier one.
- R8: When the sweep ends with a best length above zero, the engine programs the best shift and the delay floor((start+end)/2), repeats the lock, init and settle waits, and leaves `ctlRun` high. It then pulses `done` for exactly one cycle, and `bestCount`, `bestShift` and `finalDelay` show the result.
- R9: If no point passes, `noWindow` goes to 1, `bestCount` reads 0, `ctlRun` stays low and `done` pulses.
- R10: If `dllLocked` or `initDone` is absent for POLL_LIMIT consecutive samples, `errTimeout` goes to 1 and `busy` goes to 0. The engine then stays frozen, with the settings of the failing point, until reset.
- R11: `ctlRun` is dropped at the end of every sweep point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a calibration when idle |
| done | output | 1 | One-cycle pulse at the end of a calibration |
| busy | output | 1 | Calibration in progress |
| ctlRun | output | 1 | Run/start control bit to the memory controller |
| ctlWrShift | output | SHIFT_W | Write-strobe shift setting |
| ctlOutShift | output | SHIFT_W | Strobe-output shift, the write shift plus offset |
| ctlLaneDly | output | LANES*DLY_W | Per-lane strobe delay fields |
| dllLocked | input | 1 | Delay line locked status |
| initDone | input | 1 | Memory initialisation complete status |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| memAddr | output | 6 | Test word index |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after memRe |
| bestCount | output | CNT_W | Length of the best passing run |
| bestShift | output | SHIFT_W | Shift value of the best run |
| finalDelay | output | DLY_W | Midpoint delay of the best run |
| noWindow | output | 1 | No passing point was found |
| errTimeout | output | 1 | A status wait timed out |

## Verification
The bench models the memory so that each (shift, delay) point passes or fails according to a table. It then looks for equal-length runs at different shifts and inside one shift; an engine using a strict greater-than would keep the earlier run. It places a passing delay at the top of one shift next to passing delays at the bottom of the next; an engine that carries the run across shifts reports a run that is too long. A memory that fails only on a second read catches an engine that reads each word once. Read counts per point expose an engine that keeps reading after a mismatch. Odd midpoints, an empty grid, and lock or init timeouts cover the rounding, no-window and fatal paths.

// File: rtl/eye_cal_pkg.sv
package eye_cal_pkg;

  localparam int PAT_WORDS = 64;
  localparam int ADDR_W    = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_LOCK, S_INIT, S_SETTLE, S_WRITE,
    S_READ, S_CHECK, S_END, S_PICK, S_FATAL
  } cal_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFirst;
    logic loadFinal;
    logic step;
    logic clrWait;
    logic incWait;
    logic clrAddr;
    logic incAddr;
    logic clrRead;
    logic incRead;
    logic markPass;
    logic markFail;
  } dp_cmd_t;

  // 64-word test pattern: four bases, each used in a 16-word group
  function automatic logic [31:0] patWord(input logic [ADDR_W-1:0] idx);
    logic [31:0] base;
    case (idx[5:4])
      2'd0:    base = 32'h0000_0000;
      2'd1:    base = 32'hAAAA_AAAA;
      2'd2:    base = 32'hA5A5_A5A5;
      default: base = 32'hAA55_AA55;
    endcase
    return (idx[1] ^ idx[3]) ? ~base : base;
  endfunction

endpackage

// File: rtl/strobe_eye_ctrl.sv
module strobe_eye_ctrl
  import eye_cal_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    dllLocked,
  input  logic    initDone,
  input  logic    pollLast,
  input  logic    settleLast,
  input  logic    addrLast,
  input  logic    readLast,
  input  logic    delayLast,
  input  logic    shiftLast,
  input  logic    bestNone,
  input  logic    mismatch,
  output dp_cmd_t cmd,
  output logic    memWe,
  output logic    memRe,
  output logic    ctlRun,
  output logic    done,
  output logic    busy,
  output logic    noWindow,
  output logic    errTimeout
);

  cal_state_t state, nxt;
  logic finalPhase;
  logic setRun, clrRun, pulseDone, setNoWin, setErr, setFinal, clrFlags;

  always_comb begin
    nxt = state;
    cmd = '0;
    memWe = 1'b0;
    memRe = 1'b0;
    setRun = 1'b0; clrRun = 1'b0; pulseDone = 1'b0;
    setNoWin = 1'b0; setErr = 1'b0; setFinal = 1'b0; clrFlags = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        cmd.loadFirst = 1'b1; clrRun = 1'b1; clrFlags = 1'b1; nxt = S_PROG;
      end
      S_PROG: begin
        setRun = 1'b1; cmd.clrWait = 1'b1; nxt = S_LOCK;
      end
      S_LOCK: begin
        if (dllLocked) begin cmd.clrWait = 1'b1; nxt = S_INIT; end
        else if (pollLast) begin setErr = 1'b1; nxt = S_FATAL; end
        else cmd.incWait = 1'b1;
      end
      S_INIT: begin
        if (initDone) begin cmd.clrWait = 1'b1; nxt = S_SETTLE; end
        else if (pollLast) begin setErr = 1'b1; nxt = S_FATAL; end
        else cmd.incWait = 1'b1;
      end
      S_SETTLE: begin
        if (!settleLast) cmd.incWait = 1'b1;
        else if (finalPhase) begin pulseDone = 1'b1; nxt = S_IDLE; end
        else begin cmd.clrAddr = 1'b1; cmd.clrRead = 1'b1; nxt = S_WRITE; end
      end
      S_WRITE: begin
        memWe = 1'b1;
        if (addrLast) begin cmd.clrAddr = 1'b1; nxt = S_READ; end
        else cmd.incAddr = 1'b1;
      end
      S_READ: begin
        memRe = 1'b1; nxt = S_CHECK;
      end
      S_CHECK: begin
        if (mismatch) begin cmd.markFail = 1'b1; nxt = S_END; end
        else if (!readLast) begin cmd.incRead = 1'b1; nxt = S_READ; end
        else if (!addrLast) begin
          cmd.clrRead = 1'b1; cmd.incAddr = 1'b1; nxt = S_READ;
        end else begin cmd.markPass = 1'b1; nxt = S_END; end
      end
      S_END: begin
        clrRun = 1'b1;
        if (delayLast && shiftLast) nxt = S_PICK;
        else begin cmd.step = 1'b1; nxt = S_PROG; end
      end
      S_PICK: begin
        if (bestNone) begin setNoWin = 1'b1; pulseDone = 1'b1; nxt = S_IDLE; end
        else begin cmd.loadFinal = 1'b1; setFinal = 1'b1; nxt = S_PROG; end
      end
      S_FATAL: nxt = S_FATAL;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      ctlRun     <= 1'b0;
      done       <= 1'b0;
      noWindow   <= 1'b0;
      errTimeout <= 1'b0;
      finalPhase <= 1'b0;
    end else begin
      state <= nxt;
      done  <= pulseDone;
      if (setRun) ctlRun <= 1'b1;
      else if (clrRun) ctlRun <= 1'b0;
      if (clrFlags) begin noWindow <= 1'b0; finalPhase <= 1'b0; end
      if (setNoWin) noWindow <= 1'b1;
      if (setFinal) finalPhase <= 1'b1;
      if (setErr) errTimeout <= 1'b1;
    end
  end

  assign busy = (state != S_IDLE) && (state != S_FATAL);

endmodule

// File: rtl/strobe_eye_dp.sv
module strobe_eye_dp
  import eye_cal_pkg::*;
#(
  parameter int SHIFT_LO   = 64,
  parameter int SHIFT_HI   = 95,
  parameter int OUT_OFFSET = 32,
  parameter int SHIFT_W    = 8,
  parameter int DLY_LO     = 1,
  parameter int DLY_HI     = 63,
  parameter int DLY_W      = 7,
  parameter int READS      = 10,
  parameter int POLL_LIMIT = 65535,
  parameter int SETTLE_CYC = 10000,
  parameter int CNT_W      = $clog2(DLY_HI - DLY_LO + 2),
  parameter int WAIT_W     = $clog2(((POLL_LIMIT > SETTLE_CYC) ? POLL_LIMIT : SETTLE_CYC) + 1),
  parameter int RD_W       = $clog2(READS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dp_cmd_t            cmd,
  input  logic [31:0]        memRdata,
  output logic [SHIFT_W-1:0] curShift,
  output logic [SHIFT_W-1:0] outShift,
  output logic [DLY_W-1:0]   curDelay,
  output logic [ADDR_W-1:0]  addr,
  output logic [31:0]        wdata,
  output logic [CNT_W-1:0]   bestCnt,
  output logic [SHIFT_W-1:0] bestShift,
  output logic [DLY_W-1:0]   midDelay,
  output logic               pollLast,
  output logic               settleLast,
  output logic               addrLast,
  output logic               readLast,
  output logic               delayLast,
  output logic               shiftLast,
  output logic               bestNone,
  output logic               mismatch
);

  localparam logic [WAIT_W-1:0] POLL_END   = WAIT_W'(POLL_LIMIT - 1);
  localparam logic [WAIT_W-1:0] SETTLE_END = WAIT_W'(SETTLE_CYC - 1);

  logic [WAIT_W-1:0] waitCnt;
  logic [RD_W-1:0]   readIdx;
  logic [CNT_W-1:0]  runCnt, runNext;
  logic [DLY_W-1:0]  runStart, startNow, bestStart, bestEnd;
  logic [DLY_W:0]    winSum;

  assign runNext  = runCnt + 1'b1;
  assign startNow = (runCnt == '0) ? curDelay : runStart;
  assign winSum   = {1'b0, bestStart} + {1'b0, bestEnd};
  assign midDelay = winSum[DLY_W:1];

  assign pollLast   = (waitCnt == POLL_END);
  assign settleLast = (waitCnt == SETTLE_END);
  assign addrLast   = (addr == ADDR_W'(PAT_WORDS - 1));
  assign readLast   = (readIdx == RD_W'(READS - 1));
  assign delayLast  = (curDelay == DLY_W'(DLY_HI));
  assign shiftLast  = (curShift == SHIFT_W'(SHIFT_HI));
  assign bestNone   = (bestCnt == '0);
  assign wdata      = patWord(addr);
  assign mismatch   = (memRdata != patWord(addr));
  assign outShift   = curShift + SHIFT_W'(OUT_OFFSET);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0; readIdx <= '0; addr <= '0;
      curShift <= '0; curDelay <= '0;
      runCnt <= '0; runStart <= '0;
      bestCnt <= '0; bestShift <= '0; bestStart <= '0; bestEnd <= '0;
    end else begin
      if (cmd.clrWait) waitCnt <= '0;
      else if (cmd.incWait) waitCnt <= waitCnt + 1'b1;
      if (cmd.clrAddr) addr <= '0;
      else if (cmd.incAddr) addr <= addr + 1'b1;
      if (cmd.clrRead) readIdx <= '0;
      else if (cmd.incRead) readIdx <= readIdx + 1'b1;

      if (cmd.loadFirst) begin
        curShift <= SHIFT_W'(SHIFT_LO);
        curDelay <= DLY_W'(DLY_LO);
        runCnt <= '0; runStart <= '0;
        bestCnt <= '0; bestShift <= '0; bestStart <= '0; bestEnd <= '0;
      end else if (cmd.step) begin
        if (delayLast) begin
          curDelay <= DLY_W'(DLY_LO);
          curShift <= curShift + 1'b1;
          runCnt   <= '0;              // each shift starts a fresh run
        end else begin
          curDelay <= curDelay + 1'b1;
        end
      end else if (cmd.loadFinal) begin
        curShift <= bestShift;
        curDelay <= midDelay;
      end

      if (cmd.markFail) runCnt <= '0;
      if (cmd.markPass) begin
        runCnt   <= runNext;
        runStart <= startNow;
        if (runNext >= bestCnt) begin  // ties go to the later run
          bestCnt   <= runNext;
          bestShift <= curShift;
          bestStart <= startNow;
          bestEnd   <= curDelay;
        end
      end
    end
  end

endmodule

// File: rtl/strobe_eye_cal.sv
module strobe_eye_cal
  import eye_cal_pkg::*;
#(
  parameter int SHIFT_LO   = 64,
  parameter int SHIFT_HI   = 95,
  parameter int OUT_OFFSET = 32,
  parameter int SHIFT_W    = 8,
  parameter int DLY_LO     = 1,
  parameter int DLY_HI     = 63,
  parameter int DLY_W      = 7,
  parameter int LANES      = 9,
  parameter int READS      = 10,
  parameter int POLL_LIMIT = 65535,
  parameter int SETTLE_CYC = 10000,
  parameter int CNT_W      = $clog2(DLY_HI - DLY_LO + 2)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  output logic                   done,
  output logic                   busy,
  output logic                   ctlRun,
  output logic [SHIFT_W-1:0]     ctlWrShift,
  output logic [SHIFT_W-1:0]     ctlOutShift,
  output logic [LANES*DLY_W-1:0] ctlLaneDly,
  input  logic                   dllLocked,
  input  logic                   initDone,
  output logic                   memWe,
  output logic                   memRe,
  output logic [5:0]             memAddr,
  output logic [31:0]            memWdata,
  input  logic [31:0]            memRdata,
  output logic [CNT_W-1:0]       bestCount,
  output logic [SHIFT_W-1:0]     bestShift,
  output logic [DLY_W-1:0]       finalDelay,
  output logic                   noWindow,
  output logic                   errTimeout
);

  dp_cmd_t cmd;
  logic pollLast, settleLast, addrLast, readLast, delayLast, shiftLast, bestNone, mismatch;
  logic [DLY_W-1:0] curDelay;

  strobe_eye_ctrl ctrl_i (
    .clk, .rstN, .start, .dllLocked, .initDone,
    .pollLast, .settleLast, .addrLast, .readLast, .delayLast, .shiftLast,
    .bestNone, .mismatch, .cmd, .memWe, .memRe, .ctlRun, .done, .busy,
    .noWindow, .errTimeout
  );

  strobe_eye_dp #(
    .SHIFT_LO(SHIFT_LO), .SHIFT_HI(SHIFT_HI), .OUT_OFFSET(OUT_OFFSET),
    .SHIFT_W(SHIFT_W), .DLY_LO(DLY_LO), .DLY_HI(DLY_HI), .DLY_W(DLY_W),
    .READS(READS), .POLL_LIMIT(POLL_LIMIT), .SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)
  ) dp_i (
    .clk, .rstN, .cmd, .memRdata,
    .curShift(ctlWrShift), .outShift(ctlOutShift), .curDelay,
    .addr(memAddr), .wdata(memWdata),
    .bestCnt(bestCount), .bestShift, .midDelay(finalDelay),
    .pollLast, .settleLast, .addrLast, .readLast, .delayLast, .shiftLast,
    .bestNone, .mismatch
  );

  // one delay value fanned out to every byte lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ctlLaneDly[g*DLY_W +: DLY_W] = curDelay;
  end

endmodule

// File: rtl/strobe_eye_cal_chk.sv
module strobe_eye_cal_chk #(
  parameter int SHIFT_LO = 64,
  parameter int SHIFT_HI = 95,
  parameter int SHIFT_W  = 8,
  parameter int DLY_W    = 7,
  parameter int LANES    = 9,
  parameter int CNT_W    = 6
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   done,
  input logic                   busy,
  input logic                   ctlRun,
  input logic [SHIFT_W-1:0]     ctlWrShift,
  input logic [LANES*DLY_W-1:0] ctlLaneDly,
  input logic                   memWe,
  input logic                   memRe,
  input logic [CNT_W-1:0]       bestCount,
  input logic [SHIFT_W-1:0]     bestShift,
  input logic                   noWindow,
  input logic                   errTimeout
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRun && $past(ctlRun)) |-> ($stable(ctlWrShift) && $stable(ctlLaneDly))); // R3

  AST_MEM_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> ctlRun); // R3

  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errTimeout |=> (errTimeout && !busy)); // R10

  AST_NOWIN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    noWindow |-> (bestCount == '0 && !ctlRun)); // R9

  AST_BEST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (bestCount != '0) |-> (bestShift >= SHIFT_W'(SHIFT_LO) && bestShift <= SHIFT_W'(SHIFT_HI))); // R7

  AST_DONE_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    (done && !noWindow) |-> ctlRun); // R8

endmodule

bind strobe_eye_cal strobe_eye_cal_chk #(
  .SHIFT_LO(SHIFT_LO), .SHIFT_HI(SHIFT_HI), .SHIFT_W(SHIFT_W),
  .DLY_W(DLY_W), .LANES(LANES), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .done(done), .busy(busy), .ctlRun(ctlRun),
  .ctlWrShift(ctlWrShift), .ctlLaneDly(ctlLaneDly), .memWe(memWe), .memRe(memRe),
  .bestCount(bestCount), .bestShift(bestShift), .noWindow(noWindow),
  .errTimeout(errTimeout)
);

// File: tb/strobe_eye_cal_tb_top.sv
module strobe_eye_cal_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SHIFT_LO = 64, SHIFT_HI = 66, OUT_OFFSET = 32, SHIFT_W = 8;
  localparam int DLY_LO = 1, DLY_HI = 8, DLY_W = 7, LANES = 9;
  localparam int READS = 2, POLL_LIMIT = 20, SETTLE_CYC = 6;
  localparam int CNT_W = $clog2(DLY_HI - DLY_LO + 2);
  localparam int NDLY = DLY_HI - DLY_LO + 1;
  localparam int NPTS = (SHIFT_HI - SHIFT_LO + 1) * NDLY;
  localparam int LOCK_LAG = 3, INIT_LAG = 5;

  typedef struct packed {
    logic [7:0] m0, m1, m2;   // pass masks for shifts 64,65,66; bit k = delay k+1
    logic [3:0] flaky;        // delay at shift 64 failing only on re-read, 0 = none
    logic [7:0] cnt;
    logic [7:0] shf;
    logic [6:0] dly;
    logic       nw;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'h1C, 8'h00, 8'h00, 4'd0, 8'd3, 8'd64, 7'd4, 1'b0},  // single window
    '{8'h0E, 8'h00, 8'h70, 4'd0, 8'd3, 8'd66, 7'd6, 1'b0},  // tie across shifts
    '{8'h00, 8'h33, 8'h00, 4'd0, 8'd2, 8'd65, 7'd5, 1'b0},  // tie inside one shift
    '{8'hFF, 8'h0F, 8'h00, 4'd0, 8'd8, 8'd64, 7'd4, 1'b0},  // longer earlier kept
    '{8'h01, 8'h00, 8'hC0, 4'd0, 8'd2, 8'd66, 7'd7, 1'b0},  // window at top edge
    '{8'h00, 8'h00, 8'h00, 4'd0, 8'd0, 8'd0,  7'd0, 1'b1},  // nothing passes
    '{8'h80, 8'h03, 8'h00, 4'd0, 8'd2, 8'd65, 7'd1, 1'b0},  // run broken at shift step
    '{8'hFF, 8'h00, 8'h00, 4'd4, 8'd4, 8'd64, 7'd6, 1'b0},  // fails only on second read
    '{8'h00, 8'h7E, 8'h00, 4'd0, 8'd6, 8'd65, 7'd4, 1'b0},  // odd midpoint
    '{8'hFF, 8'hFF, 8'hFF, 4'd0, 8'd8, 8'd66, 7'd4, 1'b0}   // all pass, last tie wins
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic done, busy, ctlRun, memWe, memRe, noWindow, errTimeout;
  logic dllLocked, initDone;
  logic [SHIFT_W-1:0] ctlWrShift, ctlOutShift, bestShift;
  logic [LANES*DLY_W-1:0] ctlLaneDly;
  logic [5:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic [CNT_W-1:0] bestCount;
  logic [DLY_W-1:0] finalDelay;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_eye_cal #(
    .SHIFT_LO(SHIFT_LO), .SHIFT_HI(SHIFT_HI), .OUT_OFFSET(OUT_OFFSET), .SHIFT_W(SHIFT_W),
    .DLY_LO(DLY_LO), .DLY_HI(DLY_HI), .DLY_W(DLY_W), .LANES(LANES), .READS(READS),
    .POLL_LIMIT(POLL_LIMIT), .SETTLE_CYC(SETTLE_CYC)
  ) dut_i (
    .clk, .rstN, .start, .done, .busy, .ctlRun, .ctlWrShift, .ctlOutShift, .ctlLaneDly,
    .dllLocked, .initDone, .memWe, .memRe, .memAddr, .memWdata, .memRdata,
    .bestCount, .bestShift, .finalDelay, .noWindow, .errTimeout
  );

  integer checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expPat(input int i);
    logic [31:0] xs [4];
    logic [15:0] ySel;
    xs[0] = 32'h00000000; xs[1] = 32'hAAAAAAAA; xs[2] = 32'hA5A5A5A5; xs[3] = 32'hAA55AA55;
    ySel = 16'h33CC;
    return ySel[i % 16] ? ~xs[i / 16] : xs[i / 16];
  endfunction

  // status and memory models
  logic [7:0] curMask [3];
  logic [3:0] flakyDly;
  logic lockBroken = 1'b0, initBroken = 1'b0;
  int runAge;
  logic [31:0] mem [64];
  int rdCnt [64];
  logic [DLY_W-1:0] lane0;
  assign lane0 = ctlLaneDly[DLY_W-1:0];
  assign dllLocked = ctlRun && runAge >= LOCK_LAG && !lockBroken;
  assign initDone  = ctlRun && runAge >= INIT_LAG && !initBroken;

  function automatic bit passAt(input int s, input int d);
    if (s < SHIFT_LO || s > SHIFT_HI || d < DLY_LO || d > DLY_HI) return 1'b0;
    return curMask[s - SHIFT_LO][d - DLY_LO];
  endfunction

  always @(posedge clk) begin
    if (!ctlRun) runAge <= 0;
    else if (runAge < 1000) runAge <= runAge + 1;
    if (memWe) begin
      mem[memAddr] <= memWdata;
      rdCnt[memAddr] <= 0;
    end
    if (memRe) begin
      if (!passAt(ctlWrShift, lane0) ||
          (ctlWrShift == SHIFT_LO && lane0 == DLY_W'(flakyDly) && rdCnt[memAddr] != 0))
        memRdata <= mem[memAddr] ^ 32'h1;
      else
        memRdata <= mem[memAddr];
      rdCnt[memAddr] <= rdCnt[memAddr] + 1;
    end
  end

  // sweep monitor
  int pointIdx, ordErr, seqErr, patErr, rdErr, readsPt, ptShift, ptDly, expRd;
  logic prevRun;
  always @(posedge clk) begin
    if (!rstN) begin
      pointIdx <= 0; ordErr <= 0; seqErr <= 0; patErr <= 0; rdErr <= 0;
      readsPt <= 0; prevRun <= 1'b0;
    end else begin
      prevRun <= ctlRun;
      if (memRe) readsPt <= readsPt + 1;
      if (ctlRun && !prevRun) begin
        ptShift <= ctlWrShift; ptDly <= lane0; readsPt <= 0;
        pointIdx <= pointIdx + 1;
        if (pointIdx < NPTS && (ctlWrShift != SHIFT_W'(SHIFT_LO + pointIdx / NDLY) ||
                                lane0 != DLY_W'(DLY_LO + pointIdx % NDLY)))
          ordErr <= ordErr + 1;
        if (ctlOutShift != ctlWrShift + SHIFT_W'(OUT_OFFSET)) ordErr <= ordErr + 1;
        for (int l = 1; l < LANES; l++)
          if (ctlLaneDly[l*DLY_W +: DLY_W] != lane0) ordErr <= ordErr + 1;
      end
      if (memWe) begin
        if (runAge < INIT_LAG + SETTLE_CYC) seqErr <= seqErr + 1;
        if (memWdata != expPat(memAddr)) patErr <= patErr + 1;
      end
      if (!ctlRun && prevRun && pointIdx <= NPTS) begin
        if (!passAt(ptShift, ptDly)) expRd = 1;
        else if (ptShift == SHIFT_LO && ptDly == int'(flakyDly)) expRd = 2;
        else expRd = 64 * READS;
        if (readsPt != expRd) rdErr <= rdErr + 1;
      end
    end
  end

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseStart();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL R3 watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    curMask[0] = 8'h00; curMask[1] = 8'h00; curMask[2] = 8'h00; flakyDly = 4'd0;
    doReset();
    // R1 reset state
    chk(done == 0 && busy == 0 && ctlRun == 0, "R1 done/busy/run", {done, busy, ctlRun}, 0);
    chk(memWe == 0 && memRe == 0, "R1 mem strobes", {memWe, memRe}, 0);
    chk(noWindow == 0 && errTimeout == 0, "R1 flags", {noWindow, errTimeout}, 0);

    for (int v = 0; v < NVEC; v++) begin
      curMask[0] = VECS[v].m0; curMask[1] = VECS[v].m1; curMask[2] = VECS[v].m2;
      flakyDly = VECS[v].flaky;
      doReset();
      pulseStart();
      chk(busy == 1, "R2 busy after start", busy, 1);
      while (!done && !errTimeout) @(negedge clk);
      chk(errTimeout == 0, "R10 no timeout in sweep", errTimeout, 0);
      chk(noWindow == VECS[v].nw, "R9 noWindow", noWindow, VECS[v].nw);
      chk(bestCount == CNT_W'(VECS[v].cnt), "R6 R7 bestCount", bestCount, VECS[v].cnt);
      chk(ordErr == 0, "R2 sweep order and lanes", ordErr, 0);
      chk(pointIdx == NPTS + (VECS[v].nw ? 0 : 1), "R2 R8 point count", pointIdx, NPTS + 1 - VECS[v].nw);
      chk(seqErr == 0, "R3 wait sequence", seqErr, 0);
      chk(patErr == 0, "R4 pattern", patErr, 0);
      chk(rdErr == 0, "R5 R11 reads per point", rdErr, 0);
      if (VECS[v].nw) begin
        chk(ctlRun == 0, "R9 run stays low", ctlRun, 0);
      end else begin
        chk(bestShift == VECS[v].shf, "R7 bestShift", bestShift, VECS[v].shf);
        chk(finalDelay == VECS[v].dly, "R8 finalDelay", finalDelay, VECS[v].dly);
        chk(ctlRun == 1 && ctlWrShift == VECS[v].shf && lane0 == VECS[v].dly,
            "R8 final programming", {ctlRun, ctlWrShift, 1'b0, lane0}, {1'b1, VECS[v].shf, 1'b0, VECS[v].dly});
        chk(ctlOutShift == VECS[v].shf + 8'd32, "R2 final out shift", ctlOutShift, VECS[v].shf + 8'd32);
      end
      @(negedge clk);
      chk(done == 0 && busy == 0, "R8 done one cycle", {done, busy}, 0);
    end

    // R10 lock never arrives
    curMask[0] = 8'hFF; lockBroken = 1'b1;
    doReset();
    pulseStart();
    repeat (POLL_LIMIT + 10) @(negedge clk);
    chk(errTimeout == 1 && busy == 0, "R10 lock timeout", {errTimeout, busy}, 2'b10);
    chk(ctlWrShift == SHIFT_LO && lane0 == DLY_LO, "R10 failing point shown", {ctlWrShift, 1'b0, lane0}, {8'd64, 1'b0, 7'd1});
    pulseStart();
    repeat (30) @(negedge clk);
    chk(errTimeout == 1 && done == 0 && memWe == 0, "R10 frozen", {errTimeout, done, memWe}, 3'b100);

    // R10 init never completes
    lockBroken = 1'b0; initBroken = 1'b1;
    doReset();
    chk(errTimeout == 0, "R1 reset clears error", errTimeout, 0);
    pulseStart();
    repeat (POLL_LIMIT + 15) @(negedge clk);
    chk(errTimeout == 1 && ctlRun == 1, "R10 init timeout", {errTimeout, ctlRun}, 2'b11);
    initBroken = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule